// File: doc/BRIEF.md
# Single-Bit Boolean Execution Unit

This unit carries out the single-bit instructions of an 8-bit microcontroller core. It keeps a one-bit accumulator, the carry flag. It reads and writes individual bits of a 256-entry bit space, which covers sixteen bytes of low internal RAM and the bit-addressable special registers. The operations are bit moves, set, clear and complement of a bit or of carry, AND and OR of carry with a bit or with its inverse, and short relative branches that test a bit or carry. No exclusive-OR bit operation exists. Software builds one from a carry move, a branch-on-clear and a carry complement.

Every valid operation finishes in one clock. The byte that holds the addressed bit comes from a combinational byte read port. When an operation changes a bit, the unit returns that byte with only the one bit altered, together with a write strobe. The next program counter value is given in the same cycle. The carry flag also appears at bit 7 of the status byte. It therefore has its own bit address, and any bit operation can use it.

Top module: `bitproc_unit`

## Requirements
- R1: A bit address below 0x80 selects bit `addr[2:0]` of byte `0x20 + addr[6:3]`.
- R2: A bit address of 0x80 or above selects bit `addr[2:0]` of byte `addr & 0xF8`.
- R3: A bit write is a read-modify-write of the containing byte. `byte_wdata` equals the read byte with only the selected bit replaced. `byte_we` is high only for MOV bit,C (2), SETB bit (6), CLR bit (7), CPL bit (8) and a taken JBC (17).
- R4: The carry operations use op codes MOV C,bit=1, SETB C=3, CLR C=4, CPL C=5, ANL C,bit=9, ANL C,/bit=10, ORL C,bit=11 and ORL C,/bit=12. Each updates carry at the clock edge, and the new value shows on `carry_o`.
- R5: Carry is also bit address 0xD7, which is bit 7 of status byte 0xD0. Reads of that bit return the carry register, and writes to it change carry.
- R6: JC=13, JB=15 and JBC=17 branch when the tested value is 1. JNC=14 and JNB=16 branch when it is 0. A taken branch gives `pc_next = seq_pc + sign_extend(rel_off)`, modulo 2^16.
- R7: When no branch is taken, `pc_next` equals `seq_pc`.
- R8: A taken JBC clears the tested bit in the same cycle. A JBC that is not taken writes nothing.
- R9: After reset, carry is 0. With `op_valid` low, or with NOP (0), nothing is written and carry keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Decoded bit operation |
| bit_addr | input | 8 | Bit address of the operand |
| rel_off | input | 8 | Signed branch offset |
| seq_pc | input | 16 | Address of the byte after the instruction |
| byte_rdata | input | 8 | Contents of the byte at `byte_addr` |
| byte_addr | output | 8 | Byte holding the addressed bit |
| byte_we | output | 1 | Byte write strobe |
| byte_wdata | output | 8 | Byte value to write back |
| pc_next | output | 16 | Next program counter |
| carry_o | output | 1 | Carry accumulator |

## Verification
A taken JBC does two things in one cycle: it branches and it clears the bit it tested. Aimed at address 0xD7, it also clears carry in that same edge. The bench provokes this with JBC on RAM bits that are set and that are clear, and with JBC on the carry address. For each case the scoreboard expects the branch target, the write strobe, the written byte and the carry seen on the next cycle, all at once. The exclusive-OR sequence (MOV C / JNB / CPL C) runs over all four input combinations. The resulting carry is then checked against the XOR computed by the bench.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;
  typedef enum logic [4:0] {
    BOP_NOP      = 5'd0,
    BOP_LD_C     = 5'd1,
    BOP_ST_C     = 5'd2,
    BOP_SET_C    = 5'd3,
    BOP_CLR_C    = 5'd4,
    BOP_INV_C    = 5'd5,
    BOP_SET_B    = 5'd6,
    BOP_CLR_B    = 5'd7,
    BOP_INV_B    = 5'd8,
    BOP_AND_B    = 5'd9,
    BOP_AND_NB   = 5'd10,
    BOP_OR_B     = 5'd11,
    BOP_OR_NB    = 5'd12,
    BOP_BR_C     = 5'd13,
    BOP_BR_NC    = 5'd14,
    BOP_BR_B     = 5'd15,
    BOP_BR_NB    = 5'd16,
    BOP_BR_BCLR  = 5'd17
  } bop_e;

  function automatic logic bop_writes_bit(bop_e o);
    return (o == BOP_ST_C) || (o == BOP_SET_B) || (o == BOP_CLR_B) ||
           (o == BOP_INV_B) || (o == BOP_BR_BCLR);
  endfunction
endpackage

// File: rtl/bitproc_addr_map.sv
module bitproc_addr_map #(
  parameter int          AW        = 8,
  parameter logic [7:0]  LOW_BASE  = 8'h20,
  parameter logic [7:0]  ACC_BADDR = 8'hD7
) (
  input  logic [AW-1:0] bit_addr,
  output logic [AW-1:0] byte_addr,
  output logic [2:0]    bit_sel,
  output logic          is_acc
);
  localparam int GRP_W = AW - 4;

  always_comb begin
    bit_sel = bit_addr[2:0];
    is_acc  = (bit_addr == ACC_BADDR[AW-1:0]);
    if (bit_addr[AW-1]) begin
      byte_addr = {bit_addr[AW-1:3], 3'b000};
    end else begin
      byte_addr = LOW_BASE[AW-1:0] + {{(AW-GRP_W){1'b0}}, bit_addr[AW-2:3]};
    end
  end
endmodule

// File: rtl/bitproc_logic.sv
module bitproc_logic
  import bitproc_pkg::*;
(
  input  logic op_valid,
  input  bop_e op,
  input  logic acc,
  input  logic bit_in,
  output logic acc_wr,
  output logic acc_new,
  output logic bit_wr,
  output logic bit_new,
  output logic taken
);
  always_comb begin
    acc_wr  = 1'b0;
    acc_new = acc;
    bit_wr  = 1'b0;
    bit_new = bit_in;
    taken   = 1'b0;
    if (op_valid) begin
      unique case (op)
        BOP_LD_C:    begin acc_wr = 1'b1; acc_new = bit_in;          end
        BOP_SET_C:   begin acc_wr = 1'b1; acc_new = 1'b1;            end
        BOP_CLR_C:   begin acc_wr = 1'b1; acc_new = 1'b0;            end
        BOP_INV_C:   begin acc_wr = 1'b1; acc_new = ~acc;            end
        BOP_AND_B:   begin acc_wr = 1'b1; acc_new = acc & bit_in;    end
        BOP_AND_NB:  begin acc_wr = 1'b1; acc_new = acc & ~bit_in;   end
        BOP_OR_B:    begin acc_wr = 1'b1; acc_new = acc | bit_in;    end
        BOP_OR_NB:   begin acc_wr = 1'b1; acc_new = acc | ~bit_in;   end
        BOP_ST_C:    begin bit_wr = 1'b1; bit_new = acc;             end
        BOP_SET_B:   begin bit_wr = 1'b1; bit_new = 1'b1;            end
        BOP_CLR_B:   begin bit_wr = 1'b1; bit_new = 1'b0;            end
        BOP_INV_B:   begin bit_wr = 1'b1; bit_new = ~bit_in;         end
        BOP_BR_C:    taken = acc;
        BOP_BR_NC:   taken = ~acc;
        BOP_BR_B:    taken = bit_in;
        BOP_BR_NB:   taken = ~bit_in;
        BOP_BR_BCLR: begin
          taken   = bit_in;
          bit_wr  = bit_in;
          bit_new = 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bitproc_target.sv
module bitproc_target #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic [PC_W-1:0]  seq_pc,
  input  logic [OFF_W-1:0] rel_off,
  input  logic             taken,
  output logic [PC_W-1:0]  pc_next
);
  localparam int EXT_W = PC_W - OFF_W;
  logic [PC_W-1:0] off_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign off_ext = {{EXT_W{rel_off[OFF_W-1]}}, rel_off};
    end else begin : g_noext
      assign off_ext = rel_off[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    pc_next = taken ? (seq_pc + off_ext) : seq_pc;
  end
endmodule

// File: rtl/bitproc_unit.sv
module bitproc_unit
  import bitproc_pkg::*;
#(
  parameter int         AW        = 8,
  parameter int         PC_W      = 16,
  parameter int         OFF_W     = 8,
  parameter logic [7:0] LOW_BASE  = 8'h20,
  parameter logic [7:0] STAT_BYTE = 8'hD0,
  parameter int         ACC_POS   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [4:0]       op_code,
  input  logic [AW-1:0]    bit_addr,
  input  logic [OFF_W-1:0] rel_off,
  input  logic [PC_W-1:0]  seq_pc,
  input  logic [7:0]       byte_rdata,
  output logic [AW-1:0]    byte_addr,
  output logic             byte_we,
  output logic [7:0]       byte_wdata,
  output logic [PC_W-1:0]  pc_next,
  output logic             carry_o
);
  localparam logic [7:0] ACC_BADDR = {STAT_BYTE[7:3], 3'(ACC_POS)};

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ok_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok_n = rst_pipe[1];

  bop_e op;
  assign op = bop_e'(op_code);

  logic [2:0] bit_sel;
  logic       is_acc;
  bitproc_addr_map #(.AW(AW), .LOW_BASE(LOW_BASE), .ACC_BADDR(ACC_BADDR)) u_map (
    .bit_addr (bit_addr),
    .byte_addr(byte_addr),
    .bit_sel  (bit_sel),
    .is_acc   (is_acc)
  );

  logic carry_q, carry_d, carry_en;
  logic [7:0] rd_view;
  logic       on_stat;
  assign on_stat = (byte_addr == STAT_BYTE[AW-1:0]);

  // carry overlays its slot in the status byte
  genvar gi;
  generate
    for (gi = 0; gi < 8; gi++) begin : g_view
      if (gi == ACC_POS) begin : g_acc
        assign rd_view[gi] = on_stat ? carry_q : byte_rdata[gi];
      end else begin : g_pass
        assign rd_view[gi] = byte_rdata[gi];
      end
    end
  endgenerate

  logic bit_in, acc_wr, acc_new, bit_wr, bit_new, taken;
  assign bit_in = rd_view[bit_sel];

  bitproc_logic u_logic (
    .op_valid(op_valid & rst_ok_n),
    .op      (op),
    .acc     (carry_q),
    .bit_in  (bit_in),
    .acc_wr  (acc_wr),
    .acc_new (acc_new),
    .bit_wr  (bit_wr),
    .bit_new (bit_new),
    .taken   (taken)
  );

  bitproc_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
    .seq_pc (seq_pc),
    .rel_off(rel_off),
    .taken  (taken),
    .pc_next(pc_next)
  );

  generate
    for (gi = 0; gi < 8; gi++) begin : g_wr
      assign byte_wdata[gi] = (bit_sel == 3'(gi)) ? bit_new : rd_view[gi];
    end
  endgenerate
  assign byte_we = bit_wr;

  // carry next state
  always_comb begin
    carry_en = acc_wr | (bit_wr & is_acc);
    carry_d  = carry_q;
    if (acc_wr)                carry_d = acc_new;
    else if (bit_wr && is_acc) carry_d = bit_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        carry_q <= 1'b0;
    else if (carry_en) carry_q <= carry_d;
  end
  assign carry_o = carry_q;

  // assertions
  p_low_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_addr[AW-1]) |-> (byte_addr[AW-1:4] == LOW_BASE[AW-1:4]));
  p_high_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_addr[AW-1] |-> (byte_addr[2:0] == 3'b000 && byte_addr[AW-1]));
  p_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we |-> ($countones(byte_wdata ^ rd_view) <= 1));
  p_we_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we |-> (op_valid && bop_writes_bit(op)));
  p_set_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok_n && op_valid && op == BOP_SET_C) |=> carry_o);
  p_self_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == BOP_LD_C && bit_addr == ACC_BADDR[AW-1:0]) |=> (carry_o == $past(carry_o)));
  p_seq_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!taken) |-> (pc_next == seq_pc));
  p_bclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == BOP_BR_BCLR && taken) |-> (byte_we && !byte_wdata[bit_sel]));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid) |-> (!byte_we && pc_next == seq_pc));
endmodule

// File: tb/bitproc_unit_bench.sv
module bitproc_unit_bench;
  localparam time CLK_P = 5ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = 5'd0;
  logic [7:0]  bit_addr = 8'h00;
  logic [7:0]  rel_off = 8'h00;
  logic [15:0] seq_pc = 16'h0000;
  logic [7:0]  byte_rdata;
  logic [7:0]  byte_addr;
  logic        byte_we;
  logic [7:0]  byte_wdata;
  logic [15:0] pc_next;
  logic        carry_o;

  always #(CLK_P/2) clk = ~clk;

  bitproc_unit u_bitproc_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .bit_addr(bit_addr), .rel_off(rel_off), .seq_pc(seq_pc),
    .byte_rdata(byte_rdata), .byte_addr(byte_addr), .byte_we(byte_we),
    .byte_wdata(byte_wdata), .pc_next(pc_next), .carry_o(carry_o)
  );

  // byte memory seen by the unit
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  logic       m_carry;
  assign byte_rdata = mem[byte_addr];
  always @(posedge clk) if (byte_we) mem[byte_addr] <= byte_wdata;

  typedef struct {
    logic [15:0] pc;
    logic        we;
    logic [7:0]  addr;
    logic [7:0]  wdata;
    logic        carry;
    string       tag;
  } exp_t;
  exp_t q[$];

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(pc_next == e.pc, e.tag, "pc", pc_next, e.pc);
        chk(byte_we == e.we, e.tag, "we", 16'(byte_we), 16'(e.we));
        chk(carry_o == e.carry, e.tag, "carry", 16'(carry_o), 16'(e.carry));
        if (e.we && byte_we) begin
          chk(byte_addr == e.addr, e.tag, "addr", 16'(byte_addr), 16'(e.addr));
          chk(byte_wdata == e.wdata, e.tag, "wdata", 16'(byte_wdata), 16'(e.wdata));
        end
      end
    end
  end

  function automatic logic [7:0] map_byte(input logic [7:0] a);
    if (a < 8'h80) return 8'h20 + {5'd0, a[6:4], 1'b0} / 2 + 8'(a[6:3]) - 8'({5'd0, a[6:4], 1'b0} / 2);
    return a & 8'hF8;
  endfunction

  // driver: computes expected result from the requirements and queues it
  task automatic do_op(input logic v, input logic [4:0] op, input logic [7:0] a,
                       input logic [7:0] off, input logic [15:0] pc, input string tag);
    exp_t e;
    logic [7:0] ba, rd, wd;
    logic b, nb, wr, tk;
    @(negedge clk);
    op_valid = v; op_code = op; bit_addr = a; rel_off = off; seq_pc = pc;
    ba = map_byte(a);
    rd = shadow[ba];
    if (ba == 8'hD0) rd[7] = m_carry;
    b = rd[a[2:0]];
    e.carry = m_carry; e.tag = tag;
    wr = 0; nb = 0; tk = 0;
    if (v) begin
      case (op)
        5'd1:  m_carry = b;
        5'd3:  m_carry = 1;
        5'd4:  m_carry = 0;
        5'd5:  m_carry = ~m_carry;
        5'd9:  m_carry = m_carry & b;
        5'd10: m_carry = m_carry & ~b;
        5'd11: m_carry = m_carry | b;
        5'd12: m_carry = m_carry | ~b;
        5'd2:  begin wr = 1; nb = m_carry; end
        5'd6:  begin wr = 1; nb = 1; end
        5'd7:  begin wr = 1; nb = 0; end
        5'd8:  begin wr = 1; nb = ~b; end
        5'd13: tk = m_carry;
        5'd14: tk = ~m_carry;
        5'd15: tk = b;
        5'd16: tk = ~b;
        5'd17: begin tk = b; wr = b; nb = 0; end
        default: ;
      endcase
    end
    wd = rd; wd[a[2:0]] = nb;
    if (wr) begin
      shadow[ba] = wd;
      if (a == 8'hD7) m_carry = nb;
    end
    e.we = wr; e.addr = ba; e.wdata = wd;
    e.pc = tk ? pc + {{8{off[7]}}, off} : pc;
    q.push_back(e);
  endtask

  task automatic op1(input logic [4:0] op, input logic [7:0] a, input string tag);
    do_op(1, op, a, 8'h00, 16'h1000, tag);
  endtask

  function automatic logic peek(input logic [7:0] a);
    logic [7:0] ba;
    ba = map_byte(a);
    if (a == 8'hD7) return m_carry;
    return shadow[ba][a[2:0]];
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37) ^ 8'h5A;
      shadow[i] = 8'(i * 37) ^ 8'h5A;
    end
    m_carry = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R9 reset state and idle
    do_op(0, 5'd6, 8'h05, 8'h10, 16'h0200, "R9 reset idle");
    do_op(1, 5'd0, 8'h05, 8'h10, 16'h0204, "R9 nop");
    // R4 carry ops
    op1(5'd3, 8'h00, "R4 setb c");
    op1(5'd5, 8'h00, "R4 cpl c");
    op1(5'd5, 8'h00, "R4 cpl c again");
    op1(5'd4, 8'h00, "R4 clr c");
    // R1 low region, R3 single-bit writes
    op1(5'd6, 8'h00, "R1 setb 00");
    op1(5'd7, 8'h7F, "R1 clr 7f");
    op1(5'd8, 8'h35, "R1 cpl 35");
    op1(5'd6, 8'h7F, "R3 setb 7f");
    // R2 high region
    op1(5'd8, 8'h93, "R2 cpl 93");
    op1(5'd6, 8'hE5, "R2 setb e5");
    op1(5'd1, 8'h93, "R2 mov c,93");
    op1(5'd2, 8'h41, "R3 mov 41,c");
    // R4 and/or variants
    op1(5'd3, 8'h00, "R4 setb c");
    op1(5'd9, 8'h35, "R4 anl");
    op1(5'd11, 8'h00, "R4 orl");
    op1(5'd10, 8'h00, "R4 anl not");
    op1(5'd12, 8'h7F, "R4 orl not");
    op1(5'd12, 8'h35, "R4 orl not b");
    // R5 carry address
    op1(5'd7, 8'hD7, "R5 clr d7");
    op1(5'd8, 8'hD7, "R5 cpl d7");
    op1(5'd1, 8'hD7, "R5 mov c,c");
    op1(5'd6, 8'hD0, "R5 setb parity");
    op1(5'd2, 8'h02, "R5 store c");
    // R6/R7 branches
    do_op(1, 5'd13, 8'h00, 8'h10, 16'h2000, "R6 jc");
    do_op(1, 5'd14, 8'h00, 8'h10, 16'h2000, "R7 jnc");
    do_op(1, 5'd15, 8'hD0, 8'hF0, 16'h3000, "R6 jb parity back");
    do_op(1, 5'd16, 8'hD0, 8'hF0, 16'h3000, "R7 jnb parity");
    do_op(1, 5'd15, 8'h00, 8'h7F, 16'hFFF0, "R6 jb wrap up");
    do_op(1, 5'd7, 8'h00, 8'h00, 16'h0000, "R3 clr 00");
    do_op(1, 5'd16, 8'h00, 8'h80, 16'h0005, "R6 jnb wrap down");
    do_op(1, 5'd15, 8'h00, 8'h80, 16'h0005, "R7 jb not");
    // R8 test-and-clear
    do_op(1, 5'd6, 8'h50, 8'h00, 16'h0100, "R8 prep");
    do_op(1, 5'd17, 8'h50, 8'h20, 16'h0100, "R8 jbc taken");
    do_op(1, 5'd17, 8'h50, 8'h20, 16'h0100, "R8 jbc not taken");
    do_op(1, 5'd3, 8'h00, 8'h00, 16'h0100, "R8 setb c");
    do_op(1, 5'd17, 8'hD7, 8'hFE, 16'h0100, "R8 jbc carry");
    do_op(1, 5'd17, 8'hD7, 8'hFE, 16'h0100, "R8 jbc carry clear");
    // R4 xor built from mov / jnb / cpl
    for (int k = 0; k < 4; k++) begin
      do_op(1, (k & 1) ? 5'd6 : 5'd7, 8'h10, 8'h00, 16'h0400, "R4 xor prep");
      do_op(1, (k & 2) ? 5'd6 : 5'd7, 8'h11, 8'h00, 16'h0400, "R4 xor prep");
      do_op(1, 5'd1, 8'h10, 8'h00, 16'h0400, "R4 xor mov");
      do_op(1, 5'd16, 8'h11, 8'h02, 16'h0402, "R4 xor jnb");
      if (peek(8'h11)) do_op(1, 5'd5, 8'h00, 8'h00, 16'h0403, "R4 xor cpl");
      do_op(0, 5'd0, 8'h00, 8'h00, 16'h0404, "R4 xor result");
      chk(m_carry == (((k & 1) != 0) ^ ((k & 2) != 0)), "R4", "xor model",
          16'(m_carry), 16'(((k & 1) != 0) ^ ((k & 2) != 0)));
    end
    // R9 idle keeps carry with write-class op presented
    do_op(0, 5'd7, 8'hD7, 8'h00, 16'h0500, "R9 invalid");
    do_op(0, 5'd0, 8'hD7, 8'h00, 16'h0500, "R9 after invalid");
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R9", "queue drained", 16'(q.size()), 16'd0);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] want;
      want = shadow[i];
      if (i == 8'hD0) want[7] = mem[i][7];
      if (mem[i] != want) chk(0, "R3", "mem image", 16'(mem[i]), 16'(want));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule